// File: doc/BRIEF.md
# Trigger-Synchronized Multi-Channel PWM Engine

The engine holds a row of identical down-counting timers. The highest-numbered timer is reserved as the period timer, so the duty channels number one fewer than the timers. Once started, the period timer free-runs and produces a square wave with equal high and low halves. Each rising edge of that wave starts every armed channel timer as a one-shot. The channel loads its compare value, raises its output, counts down one step per clock, and drops its output when the count is spent. There is no shared up-counter with a comparator.

Software-style writes reach the block through a single write port. A write carries a kind, a channel number and a data word. The kinds are:
- a duty fraction, scaled in hardware against the current period;
- a raw compare value;
- a pin mode;
- the period in ticks;
- run or stop.

Pin modes enforce a handover order. A pin goes from idle to armed to driven on the way up, and from driven to armed to idle on the way down. The pad is therefore never driven before the channel timer is already tracking the trigger.

Top module: `trig_pwm`

## Requirements
- R1: Channel number n (1 up to NUM_TIMERS-1) on `wr_idx_i` addresses pin pair n-1. Writes with channel number 0, or above NUM_TIMERS-1, change no channel.
- R2: Kind 3 stores the period PER (CNT_W bits). Kind 4 with data[1:0]=3, issued while stopped, starts the trigger. The trigger goes high on that write's clock edge. It then toggles every H = max(PER>>1, 1) cycles, so rising edges are 2H cycles apart.
- R3: Kind 4 with data[1:0]=0 stops the engine. On that clock edge `trig_o` and every `pwm_o` bit go low, and they stay low while stopped.
- R4: An armed channel with compare C>0 goes high one cycle after each trigger rise and stays high for exactly C cycles.
- R5: Kind 0 writes a duty fraction d. The channel compare becomes (d*PER + 2^(CNT_W-1)) >> CNT_W, using the PER held at the time of the write.
- R6: Kind 1 (raw compare) and kind 0 writes are latched. The pulse already in progress keeps its old width. The new value applies from the next trigger rise.
- R7: A compare of 0 keeps the channel output constantly low.
- R8: A compare of 2H or more keeps the output high across trigger edges.
- R9: Kind 2 sets the pin mode from data[1:0]. The modes are:
  - 0, idle: `pwm_oe_o` and `pwm_o` are 0 and the timer is held.
  - 2, armed: `pwm_oe_o` and `pwm_o` are 0, but the timer runs.
  - 3, driven: `pwm_oe_o` is 1 and `pwm_o` follows the timer.
  - A write of mode 1 is ignored.
- R10: Mode 3 is accepted only from mode 2, and mode 0 only from mode 2. Mode 2 is accepted from any mode. A channel taken from mode 2 to mode 3 while its timer is high drives high at once.
- R11: A compare or duty write leaves the channel's pin mode unchanged.
- R12: After reset all outputs are 0, the engine is stopped, and all modes, compares and the period are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock; every counter steps on it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_kind_i | input | 3 | 0 duty, 1 raw compare, 2 pin mode, 3 period, 4 run/stop |
| wr_idx_i | input | IDX_W | Channel number, counted from 1 |
| wr_data_i | input | CNT_W | Write data |
| trig_o | output | 1 | Period timer square wave |
| pwm_o | output | NUM_TIMERS-1 | Channel pin values |
| pwm_oe_o | output | NUM_TIMERS-1 | Channel pin output enables |

## Verification
The bench builds the engine with NUM_TIMERS=4 and CNT_W=16, which gives three duty channels and a three-bit channel number. This makes channel number 0 and channel number 4 reachable, so both kinds of rejected write can be tried. Periods from 2 to 10 ticks keep the trigger short, so each window of the sweep covers several full trigger periods. Every sample is compared against a closed-form position-in-period formula. The compares are swept across 0, 1, mid-period, 2H-1, 2H and 65535, and duty fractions are swept across both sides of the rounding boundary.

// File: rtl/trig_pwm_pkg.sv
`timescale 1ns/1ps
package trig_pwm_pkg;
  typedef enum logic [2:0] {
    WK_DUTY   = 3'd0,
    WK_CMP    = 3'd1,
    WK_PMODE  = 3'd2,
    WK_PERIOD = 3'd3,
    WK_RUN    = 3'd4
  } wr_kind_e;

  typedef enum logic [1:0] {
    PM_OFF   = 2'd0,
    PM_RSVD  = 2'd1,
    PM_ARMED = 2'd2,
    PM_DRIVE = 2'd3
  } pin_mode_e;
endpackage

// File: rtl/trig_pwm_period.sv
`timescale 1ns/1ps
module trig_pwm_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             per_we_i,
  input  logic             run_we_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] per_o,
  output logic             active_o,
  output logic             trig_o,
  output logic             rise_o
);
  logic [CNT_W-1:0] per_q, cnt_q, half, half_eff, reload;
  logic             run_q, trig_q, rise_q;

  assign half     = per_q >> 1;
  assign half_eff = (half == '0) ? CNT_W'(1) : half;
  assign reload   = half_eff - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      trig_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      if (per_we_i) per_q <= wr_data_i;
      if (run_we_i && wr_data_i[1:0] == 2'd0) begin
        run_q  <= 1'b0;
        trig_q <= 1'b0;
        cnt_q  <= '0;
      end else if (run_we_i && wr_data_i[1:0] == 2'd3 && !run_q) begin
        run_q  <= 1'b1;
        trig_q <= 1'b1;
        rise_q <= 1'b1;
        cnt_q  <= reload;
      end else if (run_q) begin
        if (cnt_q == '0) begin
          cnt_q  <= reload;
          trig_q <= ~trig_q;
          rise_q <= ~trig_q;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign per_o    = per_q;
  assign active_o = run_q;
  assign trig_o   = trig_q;
  assign rise_o   = rise_q;

  a_r3_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !trig_q) else $error("trigger high while stopped");

  a_r2_rise_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> trig_q) else $error("rise pulse without high trigger");

  a_r2_toggle_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && !$stable(trig_q)) |-> ($past(cnt_q) == '0))
    else $error("trigger toggled before half period expired");
endmodule

// File: rtl/trig_pwm_duty_scale.sv
`timescale 1ns/1ps
module trig_pwm_duty_scale #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cmp_o
);
  localparam int PW = 2 * CNT_W;
  localparam logic [PW-1:0] RND = PW'(1) << (CNT_W - 1);

  logic [PW-1:0] prod;
  assign prod  = PW'(duty_i) * PW'(per_i) + RND;
  assign cmp_o = CNT_W'(prod >> CNT_W);
endmodule

// File: rtl/trig_pwm_chan.sv
`timescale 1ns/1ps
module trig_pwm_chan
  import trig_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             rise_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             mode_we_i,
  input  logic [1:0]       mode_i,
  output logic             pwm_o,
  output logic             oe_o
);
  pin_mode_e        mode_q, mode_new;
  logic [CNT_W-1:0] cmp_q, cnt_q;
  logic             run_q, armed, mode_ok;

  assign mode_new = pin_mode_e'(mode_i);
  assign armed    = (mode_q == PM_ARMED) || (mode_q == PM_DRIVE);

  // handover order: off <-> armed <-> drive
  always_comb begin
    unique case (mode_new)
      PM_ARMED: mode_ok = 1'b1;
      PM_DRIVE: mode_ok = (mode_q == PM_ARMED);
      PM_OFF:   mode_ok = (mode_q == PM_ARMED);
      default:  mode_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PM_OFF;
      cmp_q  <= '0;
    end else begin
      if (cmp_we_i) cmp_q <= cmp_i;
      if (mode_we_i && mode_ok) mode_q <= mode_new;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!active_i || !armed) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (rise_i) begin
      if (cmp_q == '0) begin
        run_q <= 1'b0;
      end else begin
        run_q <= 1'b1;
        cnt_q <= cmp_q - CNT_W'(1);
      end
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign oe_o  = (mode_q == PM_DRIVE);
  assign pwm_o = (mode_q == PM_DRIVE) && active_i && run_q;

  a_r9_undriven_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !pwm_o) else $error("pin value without output enable");

  a_r10_oe_handover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> ($past(mode_q) == PM_ARMED)) else $error("drive entered not from armed");

  a_r3_stopped_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !pwm_o) else $error("output high while stopped");

  a_r7_zero_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && armed && rise_i && cmp_q == '0) |=> !run_q) else $error("zero compare started pulse");

  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && armed && rise_i && cmp_q != '0) |=> run_q) else $error("pulse not started on rise");
endmodule

// File: rtl/trig_pwm.sv
`timescale 1ns/1ps
module trig_pwm
  import trig_pwm_pkg::*;
#(
  parameter int NUM_TIMERS = 8,
  parameter int CNT_W      = 16,
  parameter int IDX_W      = $clog2(NUM_TIMERS) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [2:0]            wr_kind_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [CNT_W-1:0]      wr_data_i,
  output logic                  trig_o,
  output logic [NUM_TIMERS-2:0] pwm_o,
  output logic [NUM_TIMERS-2:0] pwm_oe_o
);
  localparam int NUM_CH = NUM_TIMERS - 1;

  wr_kind_e         kind;
  logic [CNT_W-1:0] per, duty_cmp, cmp_val;
  logic             active, rise, cmp_kind;
  logic [NUM_CH-1:0] sel;

  assign kind     = wr_kind_e'(wr_kind_i);
  assign cmp_kind = (kind == WK_DUTY) || (kind == WK_CMP);
  assign cmp_val  = (kind == WK_DUTY) ? duty_cmp : wr_data_i;

  trig_pwm_period #(.CNT_W(CNT_W)) u_period (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .per_we_i  (wr_en_i && kind == WK_PERIOD),
    .run_we_i  (wr_en_i && kind == WK_RUN),
    .wr_data_i (wr_data_i),
    .per_o     (per),
    .active_o  (active),
    .trig_o    (trig_o),
    .rise_o    (rise)
  );

  trig_pwm_duty_scale #(.CNT_W(CNT_W)) u_scale (
    .duty_i (wr_data_i),
    .per_i  (per),
    .cmp_o  (duty_cmp)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign sel[i] = wr_en_i && (wr_idx_i == IDX_W'(i + 1));
    trig_pwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .active_i  (active),
      .rise_i    (rise),
      .cmp_we_i  (sel[i] && cmp_kind),
      .cmp_i     (cmp_val),
      .mode_we_i (sel[i] && kind == WK_PMODE),
      .mode_i    (wr_data_i[1:0]),
      .pwm_o     (pwm_o[i]),
      .oe_o      (pwm_oe_o[i])
    );
  end

  a_r1_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel)) else $error("write reached more than one channel");

  a_r3_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && kind == WK_RUN && wr_data_i[1:0] == 2'd0) |=> (!trig_o && pwm_o == '0))
    else $error("stop left outputs high");
endmodule

// File: tb/trig_pwm_tb.sv
`timescale 1ns/1ps
module trig_pwm_tb;
  localparam int NT = 4;
  localparam int NC = NT - 1;
  localparam int CW = 16;
  localparam int IW = 3;
  localparam logic [2:0] K_DUTY = 3'd0, K_CMP = 3'd1, K_MODE = 3'd2, K_PER = 3'd3, K_RUN = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_kind = '0;
  logic [IW-1:0] wr_idx = '0;
  logic [CW-1:0] wr_data = '0;
  logic trig;
  logic [NC-1:0] pwm, oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int h_cur = 1;
  int cmp_m [NC];

  always #2.5 clk = ~clk;

  trig_pwm #(.NUM_TIMERS(NT), .CNT_W(CW), .IDX_W(IW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_kind_i(wr_kind),
    .wr_idx_i(wr_idx), .wr_data_i(wr_data), .trig_o(trig), .pwm_o(pwm), .pwm_oe_o(oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] k, input int idx, input int d);
    wr_en = 1'b1; wr_kind = k; wr_idx = IW'(idx); wr_data = CW'(d);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stop_chk(input string req);
    wr(K_RUN, 0, 0);
    chk(!trig && pwm == '0, req, {28'd0, trig, pwm}, 0);
    repeat (5) @(negedge clk);
    chk(!trig && pwm == '0, req, {28'd0, trig, pwm}, 0);
  endtask

  // sample k = cycles since the start edge; optional raw compare write at wpos
  task automatic window(input int nsamp, input int wpos, input int wch, input int wval, input string req);
    for (int k = 0; k < nsamp; k++) begin
      logic [NC-1:0] ep;
      bit et;
      et = (k % (2 * h_cur)) < h_cur;
      for (int c = 0; c < NC; c++) begin
        int r, s, cv;
        ep[c] = 1'b0;
        if (k >= 1) begin
          r = (k - 1) / (2 * h_cur);
          s = 1 + 2 * h_cur * r;
          cv = (wpos >= 0 && c == wch && s >= wpos + 2) ? wval : cmp_m[c];
          ep[c] = (k - s) < cv;
        end
      end
      chk(trig == et, "R2", int'(trig), int'(et));
      chk(pwm == ep, req, int'(pwm), int'(ep));
      chk(oe == '1, "R11", int'(oe), 7);
      if (k == wpos) begin
        wr_en = 1'b1; wr_kind = K_CMP; wr_idx = IW'(wch + 1); wr_data = CW'(wval);
      end
      @(negedge clk);
      if (k == wpos) wr_en = 1'b0;
    end
    if (wpos >= 0) cmp_m[wch] = wval;
  endtask

  task automatic run_cfg(input int per, input int c0, input int c1, input int c2, input string req);
    wr(K_RUN, 0, 0);
    wr(K_PER, 0, per);
    wr(K_CMP, 1, c0); cmp_m[0] = c0;
    wr(K_CMP, 2, c1); cmp_m[1] = c1;
    wr(K_CMP, 3, c2); cmp_m[2] = c2;
    h_cur = ((per >> 1) == 0) ? 1 : (per >> 1);
    wr(K_RUN, 0, 3);
    window(8 * h_cur + 4, -1, 0, 0, req);
    stop_chk("R3");
  endtask

  task automatic duty_case(input int per, input int d);
    longint p;
    wr(K_RUN, 0, 0);
    wr(K_PER, 0, per);
    wr(K_DUTY, 2, d);
    p = (longint'(d) * longint'(per) + 64'd32768) >> 16;
    cmp_m[1] = int'(p);
    h_cur = ((per >> 1) == 0) ? 1 : (per >> 1);
    wr(K_RUN, 0, 3);
    window(8 * h_cur + 4, -1, 0, 0, "R5");
    stop_chk("R3");
  endtask

  initial begin
    int pers [4] = '{2, 3, 6, 10};
    int duties [6] = '{0, 3276, 3277, 32768, 52000, 65535};
    for (int i = 0; i < NC; i++) cmp_m[i] = 0;
    repeat (3) @(negedge clk);
    chk(trig == 1'b0 && pwm == '0 && oe == '0, "R12", {28'd0, trig, pwm}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trig == 1'b0 && pwm == '0 && oe == '0, "R12", {28'd0, trig, oe}, 0);

    // R10: direct jump to drive is refused
    wr(K_MODE, 1, 3);
    chk(oe == 3'b000, "R10", int'(oe), 0);
    for (int c = 1; c <= NC; c++) begin
      wr(K_MODE, c, 2);
      wr(K_MODE, c, 3);
    end
    chk(oe == 3'b111, "R9", int'(oe), 7);

    foreach (pers[i]) begin
      int h;
      h = ((pers[i] >> 1) == 0) ? 1 : (pers[i] >> 1);
      run_cfg(pers[i], 0, 1, h, "R4/R7");
      run_cfg(pers[i], 2 * h - 1, 2 * h, 2 * h + 3, "R4/R8");
      run_cfg(pers[i], 1, h + 1, 65535, "R8");
    end

    foreach (duties[i]) duty_case(10, duties[i]);

    // R6: mid-pulse compare change waits for the next rise
    wr(K_RUN, 0, 0);
    wr(K_PER, 0, 10); h_cur = 5;
    wr(K_CMP, 1, 6); cmp_m[0] = 6;
    wr(K_CMP, 2, 3); cmp_m[1] = 3;
    wr(K_CMP, 3, 0); cmp_m[2] = 0;
    wr(K_RUN, 0, 3);
    window(40, 2, 0, 2, "R6");
    stop_chk("R3");

    // R1: rejected channel numbers change nothing
    wr(K_CMP, 0, 4); wr(K_CMP, 4, 4);
    wr(K_MODE, 0, 2); wr(K_MODE, 4, 2);
    chk(oe == 3'b111, "R1", int'(oe), 7);
    h_cur = 5;
    wr(K_RUN, 0, 3);
    window(30, -1, 0, 0, "R1");
    stop_chk("R3");

    // pin-mode handover, all compares long
    wr(K_PER, 0, 6); h_cur = 3;
    wr(K_CMP, 1, 100); wr(K_CMP, 2, 100); wr(K_CMP, 3, 0);
    wr(K_RUN, 0, 3);
    repeat (3) @(negedge clk);
    chk(pwm == 3'b011, "R8", int'(pwm), 3);
    wr(K_MODE, 1, 2);
    chk(oe == 3'b110 && pwm == 3'b010, "R9", int'(pwm), 2);
    repeat (7) @(negedge clk);
    chk(pwm == 3'b010, "R9", int'(pwm), 2);
    wr(K_MODE, 1, 3);
    chk(oe[0] && pwm[0], "R10", int'(pwm), 3);
    wr(K_MODE, 1, 0);
    chk(oe[0] && pwm[0], "R10", int'(oe), 7);
    wr(K_MODE, 1, 1);
    chk(oe[0] && pwm[0], "R9", int'(oe), 7);
    wr(K_MODE, 1, 2);
    wr(K_MODE, 1, 0);
    chk(!oe[0] && !pwm[0], "R10", int'(oe), 6);
    wr(K_MODE, 1, 3);
    chk(!oe[0], "R10", int'(oe), 6);
    wr(K_MODE, 1, 2);
    repeat (8) @(negedge clk);
    wr(K_MODE, 1, 3);
    chk(oe[0] && pwm[0], "R9", int'(pwm), 3);
    // R11: compare and duty writes keep the mode
    wr(K_CMP, 2, 1);
    wr(K_DUTY, 3, 100);
    chk(oe == 3'b111, "R11", int'(oe), 7);
    stop_chk("R3");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule